// File: doc/BRIEF.md
# Eight-Line Vectored Interrupt Controller

The controller gathers eight interrupt request lines and raises one interrupt output towards a processor. It keeps three 8-bit registers, each with one bit per line. The pending register holds requests that wait for acknowledge. The service register holds lines that were acknowledged but not yet ended. The mask register stops lines from being signalled. When the processor acknowledges, the controller picks the highest-ranked unmasked pending line, moves it into service and returns an 8-bit vector. The vector is a programmable 5-bit base in the upper bits with the 3-bit line index below it. If nothing qualifies when the acknowledge arrives, the controller returns the line-7 vector as a spurious answer and sets no service bit.

Configuration is loaded through a small register-write port. It selects the mask, the detection mode (edge or level), the priority scheme (fixed or rotating), the end-of-interrupt style (command or automatic) and the vector base. The same port carries the non-specific end-of-interrupt command.

A three-state machine sequences the output side:
- `ST_IDLE` (quiet) goes to `ST_RAISE` when a qualifying request exists.
- `ST_RAISE` (irq_o high) falls back to `ST_IDLE` when the request no longer qualifies.
- Any state goes to `ST_GRANT` (vector valid for one cycle) on `ack_i`.
- `ST_GRANT` then moves to `ST_RAISE` or `ST_IDLE`, depending on whether a further request qualifies.

Top module: `irq_ctl`

## Requirements
- R1: After reset all three registers are zero, the vector base is zero, the rotation pointer marks line 7 as lowest, and irq_o and vec_valid_o are low.
- R2: In edge mode (mode bit0 = 0), a rising input edge sets the pending bit. The bit stays set after the input falls, until that line is granted.
- R3: In level mode (mode bit0 = 1), the pending bit follows the input level sampled on the previous clock, so a request that drops before acknowledge disappears.
- R4: A masked line still records in the pending register but does not raise irq_o. Clearing its mask bit later raises irq_o.
- R5: irq_o rises on the second clock edge after the request is sampled. An ack_i held for one cycle gives vec_valid_o high for exactly the next cycle, with vec_o = {base, index}. In fixed priority, line 0 ranks highest and line 7 lowest.
- R6: irq_o is high only while an unmasked pending line ranks strictly above every line set in the service register.
- R7: A write to address 3 with data bit0 = 1 is a non-specific end-of-interrupt. It clears only the highest-ranked service bit.
- R8: With automatic end-of-interrupt (mode bit2 = 1), an acknowledge sets no service bit.
- R9: With rotating priority (mode bit1 = 1), a line whose service bit is ended becomes the lowest-ranked line, and the line above it becomes the highest-ranked.
- R10: An acknowledge with no qualifying request returns {base, 3'd7} and sets no service bit.
- R11: The register map is: address 0 is the mask; address 1 is the mode; address 2 is the base, taken from data bits [7:3]; address 3 is the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Interrupt request lines |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration register address |
| cfg_wdata_i | input | 8 | Configuration write data |
| ack_i | input | 1 | Single-cycle acknowledge from the processor |
| irq_o | output | 1 | Interrupt to the processor |
| vec_valid_o | output | 1 | Vector valid, one cycle after acknowledge |
| vec_o | output | 8 | Returned vector |

## Verification
The bench builds the block with its defaults of eight lines and an 8-bit vector, which gives a 3-bit line index and a 5-bit base. At this width the rotation pointer wraps naturally. This makes it possible to check a rotation in which a numerically lower line loses to a higher one. A base of 0x20 keeps the base bits apart from the index in every compared vector.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RAISE = 2'd1,
        ST_GRANT = 2'd2
    } irq_state_e;

    typedef enum logic [1:0] {
        CFG_MASK = 2'd0,
        CFG_MODE = 2'd1,
        CFG_BASE = 2'd2,
        CFG_CMD  = 2'd3
    } cfg_addr_e;

    typedef struct packed {
        logic auto_eoi;
        logic rotate;
        logic level;
    } mode_t;

endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] req_i,
    input  logic                 level_i,
    input  logic [NUM_LINES-1:0] clear_i,
    output logic [NUM_LINES-1:0] irr_o
);

    logic [NUM_LINES-1:0] prev_q;
    logic [NUM_LINES-1:0] irr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            irr_q  <= '0;
        end else begin
            prev_q <= req_i;
            if (level_i) begin
                irr_q <= req_i;
            end else begin
                irr_q <= (irr_q & ~clear_i) | (req_i & ~prev_q);
            end
        end
    end

    assign irr_o = irr_q;

    // R2: in edge mode a pending bit only leaves on a grant
    a_r2_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_i && (clear_i == '0)) |=> ((irr_q | ~$past(irr_q)) == '1));

    // R3: in level mode the pending bits track the sampled inputs
    a_r3_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        level_i |=> (irr_q == $past(req_i)));

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 3
) (
    input  logic [NUM_LINES-1:0] bits_i,
    input  logic [IDX_W-1:0]     top_i,
    output logic                 found_o,
    output logic [IDX_W-1:0]     idx_o,
    output logic [IDX_W-1:0]     rank_o
);

    logic [IDX_W-1:0] pos;

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        rank_o  = '0;
        pos     = '0;
        for (int k = NUM_LINES - 1; k >= 0; k--) begin
            pos = top_i + IDX_W'(k);
            if (bits_i[pos]) begin
                found_o = 1'b1;
                idx_o   = pos;
                rank_o  = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
    import irq_ctl_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int VEC_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] req_i,
    input  logic                 cfg_we_i,
    input  logic [1:0]           cfg_addr_i,
    input  logic [7:0]           cfg_wdata_i,
    input  logic                 ack_i,
    output logic                 irq_o,
    output logic                 vec_valid_o,
    output logic [VEC_W-1:0]     vec_o
);

    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int BASE_W = VEC_W - IDX_W;
    localparam logic [IDX_W-1:0] LAST_LINE = IDX_W'(NUM_LINES - 1);

    irq_state_e           state_q, state_n;
    logic [NUM_LINES-1:0] imr_q, isr_q, isr_n, irr, grant_clr;
    mode_t                mode_q;
    logic [BASE_W-1:0]    base_q;
    logic [IDX_W-1:0]     lo_ptr_q, top_hi;
    logic [VEC_W-1:0]     vec_q;

    logic                 p_found, s_found;
    logic [IDX_W-1:0]     p_idx, p_rank, s_idx, s_rank;
    logic                 raise_c, take_c, eoi_c;

    irq_req_capture #(.NUM_LINES(NUM_LINES)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .level_i (mode_q.level),
        .clear_i (grant_clr),
        .irr_o   (irr)
    );

    assign top_hi = mode_q.rotate ? (lo_ptr_q + 1'b1) : '0;

    irq_prio_pick #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_pick_pend (
        .bits_i  (irr & ~imr_q),
        .top_i   (top_hi),
        .found_o (p_found),
        .idx_o   (p_idx),
        .rank_o  (p_rank)
    );

    irq_prio_pick #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_pick_isr (
        .bits_i  (isr_q),
        .top_i   (top_hi),
        .found_o (s_found),
        .idx_o   (s_idx),
        .rank_o  (s_rank)
    );

    assign raise_c   = p_found && (!s_found || (p_rank < s_rank));
    assign take_c    = ack_i && raise_c;
    assign eoi_c     = cfg_we_i && (cfg_addr_e'(cfg_addr_i) == CFG_CMD) && cfg_wdata_i[0];
    assign grant_clr = take_c ? (NUM_LINES'(1) << p_idx) : '0;

    always_comb begin
        isr_n = isr_q;
        if (eoi_c && s_found) begin
            isr_n = isr_n & ~(NUM_LINES'(1) << s_idx);
        end
        if (take_c && !mode_q.auto_eoi) begin
            isr_n = isr_n | (NUM_LINES'(1) << p_idx);
        end
    end

    // configuration, service register and rotation pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr_q    <= '0;
            mode_q   <= '0;
            base_q   <= '0;
            isr_q    <= '0;
            lo_ptr_q <= LAST_LINE;
            vec_q    <= '0;
        end else begin
            isr_q <= isr_n;
            if (cfg_we_i) begin
                unique case (cfg_addr_e'(cfg_addr_i))
                    CFG_MASK: imr_q  <= cfg_wdata_i[NUM_LINES-1:0];
                    CFG_MODE: mode_q <= mode_t'(cfg_wdata_i[2:0]);
                    CFG_BASE: base_q <= cfg_wdata_i[7:8-BASE_W];
                    CFG_CMD:  ;
                    default:  ;
                endcase
            end
            if (mode_q.rotate) begin
                if (take_c && mode_q.auto_eoi) begin
                    lo_ptr_q <= p_idx;
                end else if (eoi_c && s_found) begin
                    lo_ptr_q <= s_idx;
                end
            end
            if (ack_i) begin
                vec_q <= {base_q, (take_c ? p_idx : LAST_LINE)};
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ack_i)        state_n = ST_GRANT;
                else if (raise_c) state_n = ST_RAISE;
            end
            ST_RAISE: begin
                if (ack_i)         state_n = ST_GRANT;
                else if (!raise_c) state_n = ST_IDLE;
            end
            ST_GRANT: begin
                if (ack_i)        state_n = ST_GRANT;
                else if (raise_c) state_n = ST_RAISE;
                else              state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq_o       = (state_q == ST_RAISE);
        vec_valid_o = (state_q == ST_GRANT);
        vec_o       = vec_q;
    end

    // R4: interrupt only follows an unmasked pending request
    a_r4_irq_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(irr & ~imr_q)));

    // R5: a valid vector only follows an acknowledge
    a_r5_vec_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> $past(ack_i));

    // R8: automatic end-of-interrupt leaves the service register alone
    a_r8_auto_no_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && mode_q.auto_eoi && !eoi_c) |=> $stable(isr_q));

    // R10: a spurious acknowledge sets no service bit
    a_r10_spurious_no_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !raise_c && !eoi_c) |=> $stable(isr_q));

endmodule

// File: tb/tb_irq_ctl.sv
module tb_irq_ctl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req_i;
    logic       cfg_we_i;
    logic [1:0] cfg_addr_i;
    logic [7:0] cfg_wdata_i;
    logic       ack_i;
    logic       irq_o;
    logic       vec_valid_o;
    logic [7:0] vec_o;

    int    checks   = 0;
    int    failures = 0;
    bit    finished = 1'b0;
    logic [7:0] exp_vec[$];
    string      exp_tag[$];

    always #10 clk = ~clk;

    irq_ctl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .cfg_we_i    (cfg_we_i),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .ack_i       (ack_i),
        .irq_o       (irq_o),
        .vec_valid_o (vec_valid_o),
        .vec_o       (vec_o)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cfg_wr(input logic [1:0] a, input logic [7:0] d);
        cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
        tick(1);
        cfg_we_i = 1'b0;
    endtask

    task automatic pulse_req(input logic [7:0] m);
        req_i = req_i | m;
        tick(1);
        req_i = req_i & ~m;
    endtask

    task automatic do_ack(input logic [7:0] ev, input string tag);
        exp_vec.push_back(ev);
        exp_tag.push_back(tag);
        ack_i = 1'b1;
        tick(1);
        ack_i = 1'b0;
    endtask

    task automatic check_irq(input logic ev, input string tag);
        tick(3);
        checks++;
        if (irq_o !== ev) begin
            failures++;
            $display("FAIL %s irq_o actual=%b expected=%b", tag, irq_o, ev);
        end
    endtask

    // monitor: pops expected vectors as the design presents them
    always @(negedge clk) begin
        if (rst_n === 1'b1 && vec_valid_o === 1'b1) begin
            checks++;
            if (exp_vec.size() == 0) begin
                failures++;
                $display("FAIL R5 unexpected vector actual=%h expected=none", vec_o);
            end else begin
                automatic logic [7:0] ev = exp_vec.pop_front();
                automatic string      tg = exp_tag.pop_front();
                if (vec_o !== ev) begin
                    failures++;
                    $display("FAIL %s vec_o actual=%h expected=%h", tg, vec_o, ev);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_i = '0; cfg_we_i = 1'b0; cfg_addr_i = '0;
        cfg_wdata_i = '0; ack_i = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        checks++;
        if (irq_o !== 1'b0 || vec_valid_o !== 1'b0) begin
            failures++;
            $display("FAIL R1 irq/valid actual=%b%b expected=00", irq_o, vec_valid_o);
        end

        // R11: base from data bits [7:3]
        cfg_wr(2'd2, 8'h20);

        // R2/R5: edge request pulse stays pending
        pulse_req(8'h08);
        check_irq(1'b1, "R2");
        do_ack(8'h23, "R5 R11");
        check_irq(1'b0, "R5");
        cfg_wr(2'd3, 8'h01);
        check_irq(1'b0, "R7");

        // R5: fixed priority, line 2 beats line 5
        pulse_req(8'h24);
        check_irq(1'b1, "R5");
        do_ack(8'h22, "R5");
        check_irq(1'b0, "R6");
        cfg_wr(2'd3, 8'h01);
        check_irq(1'b1, "R6");
        do_ack(8'h25, "R5");
        cfg_wr(2'd3, 8'h01);

        // R6/R7: nesting and non-specific end
        pulse_req(8'h40);
        check_irq(1'b1, "R6");
        do_ack(8'h26, "R6");
        pulse_req(8'h02);
        check_irq(1'b1, "R6");
        do_ack(8'h21, "R6");
        cfg_wr(2'd3, 8'h01);
        pulse_req(8'h10);
        check_irq(1'b1, "R7");
        do_ack(8'h24, "R7");
        cfg_wr(2'd3, 8'h01);
        cfg_wr(2'd3, 8'h01);
        check_irq(1'b0, "R7");

        // R4: masked line still records
        cfg_wr(2'd0, 8'h08);
        pulse_req(8'h08);
        check_irq(1'b0, "R4");
        cfg_wr(2'd0, 8'h00);
        check_irq(1'b1, "R4");
        do_ack(8'h23, "R4");
        cfg_wr(2'd3, 8'h01);

        // R3/R10: level mode and spurious acknowledge
        cfg_wr(2'd1, 8'h01);
        req_i[2] = 1'b1;
        check_irq(1'b1, "R3");
        req_i[2] = 1'b0;
        check_irq(1'b0, "R3");
        do_ack(8'h27, "R10");
        req_i[7] = 1'b1;
        check_irq(1'b1, "R10");
        do_ack(8'h27, "R10");
        check_irq(1'b0, "R6");
        req_i[7] = 1'b0;
        cfg_wr(2'd3, 8'h01);
        cfg_wr(2'd1, 8'h00);

        // R8: automatic end-of-interrupt
        cfg_wr(2'd1, 8'h04);
        pulse_req(8'h10);
        check_irq(1'b1, "R8");
        do_ack(8'h24, "R8");
        pulse_req(8'h40);
        check_irq(1'b1, "R8");
        do_ack(8'h26, "R8");

        // R9: rotating priority
        cfg_wr(2'd1, 8'h02);
        pulse_req(8'h08);
        check_irq(1'b1, "R9");
        do_ack(8'h23, "R9");
        cfg_wr(2'd3, 8'h01);
        pulse_req(8'h24);
        check_irq(1'b1, "R9");
        do_ack(8'h25, "R9");
        cfg_wr(2'd3, 8'h01);
        check_irq(1'b1, "R9");
        do_ack(8'h22, "R9");
        cfg_wr(2'd3, 8'h01);
        check_irq(1'b0, "R9");

        tick(3);
        checks++;
        if (exp_vec.size() != 0) begin
            failures++;
            $display("FAIL R5 missing vectors actual=%0d expected=0", exp_vec.size());
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule